// File: doc/BRIEF.md
# In-Order Retirement Queue

The block is a circular queue that holds the speculative results of micro-operations that are still in flight. Issue logic reserves one slot per cycle at the tail. The slot index comes back as a tag, and execution units later use that tag to deposit a result value and a fault flag. Results may arrive in any order. Retirement always follows program order: only the oldest slot is examined, and it leaves the queue only once its result has arrived.

A clean oldest result is presented as a write to the architectural register file and the queue head then moves forward. A faulting oldest result does not write anything. Instead it raises a handler request carrying that operation's PC, and the queue is emptied. A misprediction input empties the queue in one cycle by moving the tail back to the head. More than one live slot may name the same destination register, and each of those slots retires separately.

Top module: `reorder_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, `alloc_tag` is 0, and neither `arch_we` nor `fault_req` is asserted.
- R2: A slot is reserved when `alloc_valid` and `alloc_ready` are both 1. `alloc_tag` shows the tail slot index and advances by one per reservation, wrapping from DEPTH-1 to 0.
- R3: When DEPTH slots are live, `alloc_ready` is 0 and a reservation request has no effect on the queue.
- R4: A writeback (`wb_valid`) stores `wb_value` and `wb_fault` into slot `wb_tag` in any order and marks that slot complete from the next cycle. A freshly reserved slot starts incomplete.
- R5: Only the head slot can retire, and only once it is complete. A clean completed head drives `arch_we`=1 with its destination and value in the same cycle, and the head advances at the next edge.
- R6: Live slots that share a destination register each retire with their own value, in reservation order.
- R7: A completed head with its fault flag set drives `fault_req`=1 and `fault_pc` with that slot's PC, and does not assert `arch_we`. The queue is empty on the next cycle, and the next tag equals the faulting slot's index.
- R8: While `flush` is 1, `arch_we`, `fault_req` and `alloc_ready` are all 0. On the next cycle the queue is empty and `alloc_tag` equals the head index.
- R9: At most one reservation and one retirement happen per cycle, and `arch_we` and `fault_req` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to reserve a slot |
| alloc_pc | input | PC_W | PC of the operation being reserved |
| alloc_dst | input | REG_W | Destination register of that operation |
| alloc_ready | output | 1 | Queue can accept a reservation this cycle |
| alloc_tag | output | $clog2(DEPTH) | Index of the slot a reservation would take |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | $clog2(DEPTH) | Slot being written back |
| wb_value | input | DATA_W | Result value |
| wb_fault | input | 1 | Result carries a fault |
| arch_we | output | 1 | Architectural register write from the head |
| arch_dst | output | REG_W | Register written by the retiring slot |
| arch_value | output | DATA_W | Value written by the retiring slot |
| fault_req | output | 1 | Handler request for a faulting head |
| fault_pc | output | PC_W | PC of the faulting slot |
| flush | input | 1 | Misprediction: discard every live slot |

## Verification
The bench builds the queue with DEPTH=4 and 16-bit values and PCs. With that depth, a full queue is reached after four reservations and the tag wraps within a handful of cycles, so full stalls, pointer wraparound and retirement across the wrap are all exercised in short sequences. Out-of-order writebacks over four slots cover the cases where the head waits while younger slots are already complete.

// File: rtl/reorder_queue.sv
module reorder_queue #(
  parameter int DEPTH  = 16,
  parameter int PC_W   = 32,
  parameter int REG_W  = 5,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic [REG_W-1:0]  alloc_dst,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  input  logic              wb_fault,
  output logic              arch_we,
  output logic [REG_W-1:0]  arch_dst,
  output logic [DATA_W-1:0] arch_value,
  output logic              fault_req,
  output logic [PC_W-1:0]   fault_pc,
  input  logic              flush
);

  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH);
  localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);

  logic [PTR_W-1:0]  head_ptr, tail_ptr, count;
  logic [IDX_W-1:0]  head_idx;
  logic [DEPTH-1:0]  done_q;
  logic [PC_W-1:0]   pc_q    [DEPTH];
  logic [REG_W-1:0]  dst_q   [DEPTH];
  logic [DATA_W-1:0] val_q   [DEPTH];
  logic [DEPTH-1:0]  fault_q;
  logic              head_ready, alloc_fire;

  assign head_idx   = head_ptr[IDX_W-1:0];
  assign alloc_tag  = tail_ptr[IDX_W-1:0];
  assign count      = tail_ptr - head_ptr;

  assign head_ready = (count != '0) && done_q[head_idx] && !flush;
  assign arch_we    = head_ready && !fault_q[head_idx];
  assign fault_req  = head_ready && fault_q[head_idx];
  assign arch_dst   = dst_q[head_idx];
  assign arch_value = val_q[head_idx];
  assign fault_pc   = pc_q[head_idx];

  assign alloc_ready = (count != FULL_CNT) && !flush && !fault_req;
  assign alloc_fire  = alloc_valid && alloc_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else begin
      if (flush || fault_req) tail_ptr <= head_ptr;
      else if (alloc_fire)    tail_ptr <= tail_ptr + ONE;
      if (arch_we)            head_ptr <= head_ptr + ONE;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        done_q[i] <= 1'b0;
      else if (alloc_fire && alloc_tag == IDX_W'(i))
        done_q[i] <= 1'b0;
      else if (wb_valid && wb_tag == IDX_W'(i))
        done_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (alloc_fire && alloc_tag == IDX_W'(i)) begin
        pc_q[i]  <= alloc_pc;
        dst_q[i] <= alloc_dst;
      end
      if (wb_valid && wb_tag == IDX_W'(i)) begin
        val_q[i]   <= wb_value;
        fault_q[i] <= wb_fault;
      end
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  // R2
  tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> tail_ptr == $past(tail_ptr) + ONE);

  // R5
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arch_we |=> head_ptr == $past(head_ptr));

  // R7
  fault_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> count == '0);

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);

  // R9
  retire_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(arch_we && fault_req));

endmodule

// File: tb/reorder_queue_test.sv
module reorder_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_ready, wb_valid, wb_fault, arch_we, fault_req, flush;
  logic [15:0] alloc_pc, wb_value, arch_value, fault_pc;
  logic [4:0]  alloc_dst, arch_dst;
  logic [IW-1:0] alloc_tag, wb_tag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_queue #(.DEPTH(DEPTH), .PC_W(16), .REG_W(5), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_dst(alloc_dst),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_fault(wb_fault),
    .arch_we(arch_we), .arch_dst(arch_dst), .arch_value(arch_value),
    .fault_req(fault_req), .fault_pc(fault_pc), .flush(flush)
  );

  // row: wb_valid, wb_tag[2], wb_value[16], exp_we, exp_dst[5], exp_val[16]
  localparam logic [40:0] VEC [8] = '{
    {1'b1, 2'd2, 16'h00B2, 1'b0, 5'd0, 16'h0000},
    {1'b1, 2'd1, 16'h00B1, 1'b0, 5'd0, 16'h0000},
    {1'b1, 2'd0, 16'h00B0, 1'b0, 5'd0, 16'h0000},
    {1'b0, 2'd0, 16'h0000, 1'b1, 5'd1, 16'h00B0},
    {1'b0, 2'd0, 16'h0000, 1'b1, 5'd7, 16'h00B1},
    {1'b1, 2'd3, 16'h00B3, 1'b1, 5'd7, 16'h00B2},
    {1'b0, 2'd0, 16'h0000, 1'b1, 5'd4, 16'h00B3},
    {1'b0, 2'd0, 16'h0000, 1'b0, 5'd0, 16'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reserve(input logic [15:0] pc, input logic [4:0] dst, input int tag);
    alloc_valid = 1'b1; alloc_pc = pc; alloc_dst = dst;
    #1;
    check("R2 ready", 32'(alloc_ready), 32'd1);
    check("R2 tag", 32'(alloc_tag), 32'(tag));
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic writeback(input int tag, input logic [15:0] val, input logic flt);
    wb_valid = 1'b1; wb_tag = IW'(tag); wb_value = val; wb_fault = flt;
    #1;
    check("R5 head waits", 32'(arch_we), 32'd0);
    @(negedge clk);
    wb_valid = 1'b0; wb_fault = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; alloc_valid = 0; alloc_pc = 0; alloc_dst = 0;
    wb_valid = 0; wb_tag = 0; wb_value = 0; wb_fault = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 ready", 32'(alloc_ready), 32'd1);
    check("R1 tag", 32'(alloc_tag), 32'd0);
    check("R1 we", 32'(arch_we), 32'd0);
    check("R1 fault", 32'(fault_req), 32'd0);
    @(negedge clk);

    // R6: slots 1 and 2 share destination 7
    reserve(16'h100, 5'd1, 0);
    reserve(16'h101, 5'd7, 1);
    reserve(16'h102, 5'd7, 2);
    reserve(16'h103, 5'd4, 3);
    alloc_valid = 1'b1; alloc_pc = 16'h1FF; alloc_dst = 5'd31;
    #1;
    check("R3 full", 32'(alloc_ready), 32'd0);
    @(negedge clk);
    alloc_valid = 1'b0;

    // R4 R5 R6: out-of-order writeback, in-order retirement
    for (int r = 0; r < 8; r++) begin
      wb_valid = VEC[r][40]; wb_tag = VEC[r][39:38]; wb_value = VEC[r][37:22];
      wb_fault = 1'b0;
      #1;
      check("R5 we", 32'(arch_we), 32'(VEC[r][21]));
      check("R9 no fault", 32'(fault_req), 32'd0);
      if (VEC[r][21]) begin
        check("R6 dst", 32'(arch_dst), 32'(VEC[r][20:16]));
        check("R4 value", 32'(arch_value), 32'(VEC[r][15:0]));
      end
      @(negedge clk);
    end
    wb_valid = 1'b0;

    // R7: faulting head
    reserve(16'h200, 5'd10, 0);
    reserve(16'h201, 5'd11, 1);
    reserve(16'h202, 5'd12, 2);
    writeback(2, 16'h0077, 1'b0);
    writeback(1, 16'h0000, 1'b1);
    writeback(0, 16'h0055, 1'b0);
    #1;
    check("R5 we", 32'(arch_we), 32'd1);
    check("R5 dst", 32'(arch_dst), 32'd10);
    check("R5 value", 32'(arch_value), 32'h55);
    @(negedge clk);
    #1;
    check("R7 fault", 32'(fault_req), 32'd1);
    check("R7 pc", 32'(fault_pc), 32'h201);
    check("R9 no we", 32'(arch_we), 32'd0);
    @(negedge clk);
    #1;
    check("R7 discarded", 32'(arch_we), 32'd0);
    check("R7 fault off", 32'(fault_req), 32'd0);
    check("R7 ready", 32'(alloc_ready), 32'd1);
    check("R7 tag", 32'(alloc_tag), 32'd1);
    @(negedge clk);

    // R8: misprediction flush
    reserve(16'h300, 5'd20, 1);
    reserve(16'h301, 5'd21, 2);
    writeback(1, 16'h0033, 1'b0);
    flush = 1'b1;
    #1;
    check("R8 we off", 32'(arch_we), 32'd0);
    check("R8 ready off", 32'(alloc_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    #1;
    check("R8 empty", 32'(arch_we), 32'd0);
    check("R8 tag", 32'(alloc_tag), 32'd1);
    check("R8 ready", 32'(alloc_ready), 32'd1);
    reserve(16'h310, 5'd22, 1);
    #1;
    check("R4 fresh incomplete", 32'(arch_we), 32'd0);
    writeback(1, 16'h0044, 1'b0);
    #1;
    check("R5 we", 32'(arch_we), 32'd1);
    check("R5 dst", 32'(arch_dst), 32'd22);
    check("R4 value", 32'(arch_value), 32'h44);
    @(negedge clk);

    // R2 R3: wraparound to full
    reserve(16'h400, 5'd2, 2);
    reserve(16'h401, 5'd3, 3);
    reserve(16'h402, 5'd5, 0);
    reserve(16'h403, 5'd6, 1);
    #1;
    check("R3 full after wrap", 32'(alloc_ready), 32'd0);
    check("R5 none done", 32'(arch_we), 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule